// File: doc/BRIEF.md
# Link Carrier Monitor with Reset Retry

This block watches the receive side of one Ethernet port and decides whether the link carries traffic. Some MACs give no interrupt when the link changes state. Their receiver also does not regain block lock on a partner signal that settles only after the most recent reset. The monitor therefore retries on its own. While no valid link is seen, it issues a pulse on the core and serdes reset once per poll period. After each pulse it waits a settle window, then checks whether block lock and receive status both stay high for a run of consecutive samples. Once a link is declared, it keeps checking every cycle and drops carrier on the first bad sample.

When software sets the enable input, the monitor starts with carrier low and begins retrying at once. A link that is slow to come up is never an error; the monitor simply keeps trying. Clearing enable stops everything: carrier goes low, reset pulses stop and the monitor waits. Every carrier change also produces a one-cycle strobe, so an interrupt controller or a counter can follow the link without polling.

The state machine has five states:
- IDLE: disabled.
- PULSE: the reset output is driven.
- SETTLE: samples are ignored.
- HUNT: consecutive good samples are counted.
- LINKED: carrier is high.

The transitions between them are:
- T_ENABLE: IDLE to PULSE, when enable is high.
- T_PULSE_DONE: PULSE to SETTLE, after the pulse length.
- T_SETTLED: SETTLE to HUNT, after the settle length.
- T_QUALIFIED: HUNT to LINKED, after enough good samples in a row.
- T_RETRY: HUNT to PULSE, when the poll period ends without qualifying.
- T_LOST: LINKED to PULSE, on a bad sample.
- T_DISABLE: any state to IDLE, when enable is low.

Top module: `link_carrier_mon`

## Requirements
- R1: While enable is low (after reset), carrier and mac_rst stay 0 and no reset pulse is issued. Clearing enable while carrier is high drops carrier at the next clock and raises link_down_evt in that same cycle.
- R2: On the first clock that sees enable high after it was low, mac_rst goes to 1 and carrier stays 0.
- R3: Every reset pulse keeps mac_rst at 1 for exactly RST_CYC cycles.
- R4: A sample counts as good only when block_lock and rx_status are both 1, each taken through SYNC_STAGES synchronizer flops. With rx_status held at 0, carrier never rises.
- R5: While no link qualifies, consecutive rising edges of mac_rst are exactly POLL_CYC cycles apart.
- R6: Samples taken during the pulse and the settle window are ignored. If the inputs are good throughout the hunt window, carrier rises exactly RST_CYC+SETTLE_CYC+UP_CNT cycles after the rising edge of mac_rst.
- R7: Carrier rises only after UP_CNT consecutive good samples. A pattern with at most UP_CNT-1 good samples between bad ones never raises carrier.
- R8: When block_lock or rx_status falls while carrier is high, carrier falls SYNC_STAGES+1 cycles later. In that same cycle mac_rst rises and link_down_evt is 1.
- R9: link_up_evt is 1 only in the first cycle with carrier high. link_down_evt is 1 only in the first cycle with carrier low after it was high.
- R10: carrier and mac_rst are never 1 at the same time.
- R11: Take a partner that locks only when a reset is released after its signal became stable, with POLL_CYC > RST_CYC+SETTLE_CYC+UP_CNT+SYNC_STAGES. Carrier then rises within 2*POLL_CYC cycles of the partner becoming stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitor enable; low forces IDLE |
| block_lock | input | 1 | Receive block lock from the PCS (asynchronous) |
| rx_status | input | 1 | Receive status from the MAC (asynchronous) |
| carrier | output | 1 | Link qualified and up |
| mac_rst | output | 1 | Core and serdes reset request pulse |
| link_up_evt | output | 1 | One-cycle strobe when carrier rises |
| link_down_evt | output | 1 | One-cycle strobe when carrier falls |

## Verification
All outputs are registered from the next state, so each result lands one edge after its cause:
- mac_rst follows enable one edge later.
- Carrier falls SYNC_STAGES+1 edges after an input drops.
- Carrier rises exactly RST_CYC+SETTLE_CYC+UP_CNT edges after a pulse begins, when the partner locks at that release.

The bench changes inputs on falling edges and samples outputs on falling edges. It timestamps every rising and falling edge of mac_rst and carrier with a cycle counter, then compares each distance with the value computed from the parameters. Open-ended results, namely recovery after a partner appears at a random time, are checked against the two-poll-period bound instead of an exact cycle.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    typedef enum logic [2:0] {
        LCM_IDLE   = 3'd0,
        LCM_PULSE  = 3'd1,
        LCM_SETTLE = 3'd2,
        LCM_HUNT   = 3'd3,
        LCM_LINKED = 3'd4
    } lcm_state_e;

endpackage

// File: rtl/lcm_sync.sv
// Multi-flop synchronizer, one chain per input bit.
module lcm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lcm_poll_timer.sv
// Cycle counter that restarts at every reset pulse and saturates at the poll limit.
module lcm_poll_timer #(
    parameter int POLL_CYC = 1000,
    localparam int TW = $clog2(POLL_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [TW-1:0] count
);

    localparam logic [TW-1:0] L_LAST = TW'(POLL_CYC - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)               count <= '0;
        else if (restart)         count <= '0;
        else if (count != L_LAST) count <= count + 1'b1;
    end

endmodule

// File: rtl/lcm_debounce.sv
// Counts consecutive good samples while armed; qualifies on the UP_CNT-th one.
module lcm_debounce #(
    parameter int UP_CNT = 16,
    localparam int CW = $clog2(UP_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic good,
    output logic qualified
);

    localparam logic [CW-1:0] L_TOP = CW'(UP_CNT - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!arm || !good)  run_q <= '0;
        else if (run_q != L_TOP) run_q <= run_q + 1'b1;
    end

    assign qualified = arm && good && (run_q == L_TOP);

    // R7: qualification needs a good sample in the previous cycle as well
    // (a run of at least two), unless a single sample suffices.
    if (UP_CNT > 1) begin : g_chk
        p_run_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
            qualified |-> $past(good))
            else $error("p_run_needed_r7");
    end

endmodule

// File: rtl/link_carrier_mon.sv
module link_carrier_mon
    import lcm_pkg::*;
#(
    parameter int POLL_CYC    = 1000000,
    parameter int RST_CYC     = 64,
    parameter int SETTLE_CYC  = 1000,
    parameter int UP_CNT      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic block_lock,
    input  logic rx_status,
    output logic carrier,
    output logic mac_rst,
    output logic link_up_evt,
    output logic link_down_evt
);

    localparam int TW = $clog2(POLL_CYC + 1);
    localparam int WW = $clog2(RST_CYC + 2);
    localparam int RW = $clog2(UP_CNT + 2);
    localparam logic [TW-1:0] L_PULSE_END  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] L_SETTLE_END = TW'(RST_CYC + SETTLE_CYC - 1);
    localparam logic [TW-1:0] L_POLL_END   = TW'(POLL_CYC - 1);

    lcm_state_e    st_q, st_nx;
    logic [1:0]    raw_in, sync_in;
    logic          good_s;
    logic          qual;
    logic          tmr_restart;
    logic [TW-1:0] tmr;

    // ---- input synchronization: R4 -------------------------------------
    assign raw_in = {block_lock, rx_status};

    lcm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign good_s = sync_in[1] & sync_in[0];

    // ---- poll timer ----------------------------------------------------
    assign tmr_restart = (st_nx == LCM_PULSE) && (st_q != LCM_PULSE);

    lcm_poll_timer #(.POLL_CYC(POLL_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .count   (tmr)
    );

    // ---- debounce --------------------------------------------------------
    lcm_debounce #(.UP_CNT(UP_CNT)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (st_q == LCM_HUNT),
        .good      (good_s),
        .qualified (qual)
    );

    // ---- next state ------------------------------------------------------
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            LCM_IDLE:   if (enable) st_nx = LCM_PULSE;                // T_ENABLE
            LCM_PULSE:  if (tmr == L_PULSE_END) st_nx = LCM_SETTLE;   // T_PULSE_DONE
            LCM_SETTLE: if (tmr == L_SETTLE_END) st_nx = LCM_HUNT;    // T_SETTLED
            LCM_HUNT: begin
                if (qual)                     st_nx = LCM_LINKED;     // T_QUALIFIED
                else if (tmr >= L_POLL_END)   st_nx = LCM_PULSE;      // T_RETRY
            end
            LCM_LINKED: if (!good_s) st_nx = LCM_PULSE;               // T_LOST
            default:    st_nx = LCM_IDLE;
        endcase
        if (!enable) st_nx = LCM_IDLE;                                // T_DISABLE
    end

    // ---- state register --------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LCM_IDLE;
        else        st_q <= st_nx;
    end

    // ---- registered outputs ----------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carrier       <= 1'b0;
            mac_rst       <= 1'b0;
            link_up_evt   <= 1'b0;
            link_down_evt <= 1'b0;
        end else begin
            carrier       <= (st_nx == LCM_LINKED);
            mac_rst       <= (st_nx == LCM_PULSE);
            link_up_evt   <= (st_nx == LCM_LINKED) && (st_q != LCM_LINKED);
            link_down_evt <= (st_q == LCM_LINKED) && (st_nx != LCM_LINKED);
        end
    end

    // ---- checker state ---------------------------------------------------
    logic [WW-1:0] chk_width;
    logic [RW-1:0] chk_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_width <= '0;
            chk_run   <= '0;
        end else begin
            chk_width <= mac_rst ? chk_width + 1'b1 : '0;
            if (!good_s)                     chk_run <= '0;
            else if (chk_run != RW'(UP_CNT)) chk_run <= chk_run + 1'b1;
        end
    end

    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !carrier && !mac_rst)
        else $error("p_idle_when_off_r1");

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> mac_rst && !carrier)
        else $error("p_start_pulse_r2");

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mac_rst) && enable) |-> (chk_width == WW'(RST_CYC)))
        else $error("p_pulse_width_r3");

    p_good_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> $past(good_s))
        else $error("p_good_gate_r4");

    p_debounce_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> (chk_run >= RW'(UP_CNT)))
        else $error("p_debounce_run_r7");

    p_loss_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier && enable && !good_s) |=> !carrier && mac_rst && link_down_evt)
        else $error("p_loss_drop_r8");

    p_up_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_evt |-> carrier && !$past(carrier))
        else $error("p_up_strobe_r9");

    p_down_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_down_evt |-> !carrier && $past(carrier))
        else $error("p_down_strobe_r9");

    p_rise_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> link_up_evt)
        else $error("p_rise_marked_r9");

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({carrier, mac_rst}))
        else $error("p_exclusive_r10");

endmodule

// File: tb/sim_link_carrier_mon.sv
module sim_link_carrier_mon;

    localparam int POLL   = 80;
    localparam int RSTC   = 4;
    localparam int SETTLE = 10;
    localparam int UPC    = 5;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic partner_on = 1'b0;
    logic status_ok = 1'b1;
    logic locked = 1'b0;
    logic block_lock, rx_status;
    logic carrier, mac_rst, link_up_evt, link_down_evt;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rst_rises = 0;
    int last_rise = 0;
    bit per_valid = 0;
    bit exact_chk = 1;
    logic m_prev_rst = 1'b0;
    logic m_prev_car = 1'b0;
    logic p_prev_rst = 1'b0;

    always #5 clk = ~clk;

    link_carrier_mon #(
        .POLL_CYC(POLL), .RST_CYC(RSTC), .SETTLE_CYC(SETTLE),
        .UP_CNT(UPC), .SYNC_STAGES(SYNC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .block_lock(block_lock), .rx_status(rx_status),
        .carrier(carrier), .mac_rst(mac_rst),
        .link_up_evt(link_up_evt), .link_down_evt(link_down_evt)
    );

    // Partner model: locks only when a reset is released while its signal is on.
    assign block_lock = partner_on & locked;
    assign rx_status  = partner_on & locked & status_ok;

    always @(negedge clk) begin
        if (!partner_on)                    locked <= 1'b0;
        else if (p_prev_rst && !mac_rst)    locked <= 1'b1;
        p_prev_rst <= mac_rst;
    end

    function automatic int exp_qual_delay();
        return RSTC + SETTLE + UPC;
    endfunction

    function automatic int exp_recovery_limit();
        return 2 * POLL;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_carrier(input int limit, input string req);
        int k = 0;
        while (!carrier && k <= limit) begin
            @(negedge clk);
            k++;
        end
        chk(carrier && k <= limit, req, k, limit);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mac_rst && !m_prev_rst) begin
                rst_rises++;
                if (per_valid) chk(cyc - last_rise == POLL, "R5", cyc - last_rise, POLL);
                last_rise = cyc;
                per_valid = 1;
            end
            if (!mac_rst && m_prev_rst && enable)
                chk(cyc - last_rise == RSTC, "R3", cyc - last_rise, RSTC);
            if (carrier && !m_prev_car) begin
                chk(link_up_evt == 1'b1, "R9", int'(link_up_evt), 1);
                if (exact_chk)
                    chk(cyc - last_rise == exp_qual_delay(), "R6", cyc - last_rise, exp_qual_delay());
                per_valid = 0;
            end
            if (!carrier && m_prev_car)
                chk(link_down_evt == 1'b1, "R9", int'(link_down_evt), 1);
            if (link_up_evt && !(carrier && !m_prev_car))
                chk(1'b0, "R9", 1, 0);
            if (link_down_evt && !(!carrier && m_prev_car))
                chk(1'b0, "R9", 1, 0);
            if (!enable) per_valid = 0;
            m_prev_rst = mac_rst;
            m_prev_car = carrier;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        int off_len;
        bit seen;
        void'($urandom(32'd1234));
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state and disabled behaviour
        chk(carrier == 0 && mac_rst == 0, "R1", int'({carrier, mac_rst}), 0);
        chk(link_up_evt == 0 && link_down_evt == 0, "R1", int'({link_up_evt, link_down_evt}), 0);
        idle(3 * POLL);
        chk(rst_rises == 0, "R1", rst_rises, 0);

        // R2 enable: pulse at once, carrier off, no partner yet
        enable = 1'b1;
        @(negedge clk);
        chk(mac_rst == 1 && carrier == 0, "R2", int'({mac_rst, carrier}), 2);
        idle(3 * POLL);
        chk(rst_rises >= 3, "R5", rst_rises, 3);
        chk(carrier == 0, "R2", int'(carrier), 0);

        // R11 partner appears
        partner_on = 1'b1;
        wait_carrier(exp_recovery_limit(), "R11");

        // R8 loss timing
        partner_on = 1'b0;
        idle(SYNC);
        chk(carrier == 1, "R8", int'(carrier), 1);
        idle(1);
        chk(carrier == 0 && mac_rst == 1 && link_down_evt == 1, "R8",
            int'({carrier, mac_rst, link_down_evt}), 3);

        // R4 status gating
        exact_chk = 0;
        status_ok = 1'b0;
        partner_on = 1'b1;
        idle(3 * POLL);
        chk(carrier == 0, "R4", int'(carrier), 0);
        status_ok = 1'b1;
        wait_carrier(exp_recovery_limit(), "R4");

        // R7 debounce: runs of UPC-1 good samples only
        partner_on = 1'b0;
        idle(5);
        partner_on = 1'b1;
        seen = 0;
        for (int i = 0; i < 3 * POLL; i++) begin
            status_ok = ((i % UPC) != UPC - 1);
            @(negedge clk);
            if (carrier) seen = 1;
        end
        chk(!seen, "R7", int'(seen), 0);
        status_ok = 1'b1;
        wait_carrier(exp_recovery_limit(), "R7");
        exact_chk = 1;

        // R1 disable while linked
        enable = 1'b0;
        @(negedge clk);
        chk(carrier == 0 && link_down_evt == 1 && mac_rst == 0, "R1",
            int'({carrier, link_down_evt, mac_rst}), 2);
        r0 = rst_rises;
        idle(3 * POLL);
        chk(rst_rises == r0 && carrier == 0, "R1", rst_rises - r0, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(mac_rst == 1 && carrier == 0, "R2", int'({mac_rst, carrier}), 2);
        wait_carrier(exp_recovery_limit(), "R11");

        // R11 random partner outages
        for (int n = 0; n < 8; n++) begin
            off_len = 3 + int'($urandom % (3 * POLL));
            partner_on = 1'b0;
            idle(off_len);
            chk(carrier == 0, "R8", int'(carrier), 0);
            partner_on = 1'b1;
            wait_carrier(exp_recovery_limit(), "R11");
            idle(1 + int'($urandom % POLL));
            chk(carrier == 1, "R8", int'(carrier), 1);
        end

        // R10 spot check at the end
        chk(!(carrier && mac_rst), "R10", int'({carrier, mac_rst}), 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule